// File: doc/BRIEF.md
# Double-Buffered Converter Load Interface

This block is the digital front end of a single-channel voltage converter with a parallel host bus. A host selects the block with an active-low select, presents a data word on a narrow bus and pulses an active-low write strobe. On the write's release the data, together with a range bit and a reference-buffer bit, is captured into a staging register. A second register holds the code that actually drives the converter. It is loaded from the staging register by an active-low load strobe, so several converters can be changed at the same instant.

The code is wider than the bus. A half-select input steers each write into either the low part or the high part of the staging register. Every strobe is sampled by a free-running system clock through a two-flop synchronizer. A level is accepted only after two consecutive equal samples, which rejects pulses shorter than two clocks. A clear strobe empties both registers, and a sleep strobe sets the power-down flag. A one-clock status pulse marks each change of the converter code.

Top module: `dac_parallel_front`

## Requirements
- R1: A write is accepted when write (active low) returns high while select (active low) is low. With upper_half = 0 it loads data_in[7:0] into bits 7:0 of the staging register and leaves bits 11:8 unchanged.
- R2: A write whose select is high changes neither the staging register nor any output.
- R3: With upper_half = 1 a write loads data_in[3:0] into bits 11:8 of the staging register and leaves bits 7:0 unchanged.
- R4: range_x2 and ref_buffered are captured at an accepted write and appear on range_x2_out and ref_buffered_out.
- R5: If the load strobe is low when a write is accepted, the converter code takes the new staging value at that same write.
- R6: A falling load strobe copies the staging register into the converter code. Without a load strobe a write leaves the code unchanged.
- R7: While clear is low, the staging register, the code and both captured control bits are forced to zero. This takes priority over a write or load in the same cycle, and all stay zero after release until a new write and load.
- R8: After reset the code is zero, both control bits are zero, power_down is 0 and code_changed is 0.
- R9: power_down follows the sleep strobe (1 while it is low) and does not alter the code or the staging register.
- R10: A strobe low for only one system clock is ignored. Two clocks are enough to be accepted.
- R11: code_changed is high for exactly one clock in each cycle where the code takes a different value. Reloading the same value gives no pulse.
- R12: An output change appears after the fourth rising clock edge following the first edge that samples the new strobe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Device select, active low |
| wstb_n | input | 1 | Write strobe, active low, acts on release |
| load_n | input | 1 | Code load strobe, active low |
| zero_n | input | 1 | Clear strobe, active low |
| sleep_n | input | 1 | Power-down request, active low |
| upper_half | input | 1 | 1 steers the write into the upper code bits |
| range_x2 | input | 1 | Output range bit captured at a write |
| ref_buffered | input | 1 | Reference buffer bit captured at a write |
| data_in | input | BUS_W | Parallel data bus |
| code_out | output | CODE_W | Converter code |
| range_x2_out | output | 1 | Captured range bit |
| ref_buffered_out | output | 1 | Captured reference buffer bit |
| power_down | output | 1 | Power-down state |
| code_changed | output | 1 | One-clock pulse when the code changes value |

## Verification
The bench builds the block with its defaults: a 12-bit code over an 8-bit bus. This width pair gives a split where the upper write carries only four meaningful bits. That makes the preservation of the untouched half, and the masking of the unused upper data lines, visible at the code output. Strobe pulses of one clock and of two clocks sit exactly on both sides of the acceptance threshold. A load issued while a write is held during a clear exercises the priority between the three strobes.

// File: rtl/dacif_pkg.sv
// Package: shared indices and types for the converter load interface.
// Assumes the strobes are active low and idle high.
package dacif_pkg;
    // Positions of the filtered strobes in the filter array
    localparam int STB_WR    = 0;
    localparam int STB_LOAD  = 1;
    localparam int STB_CLR   = 2;
    localparam int STB_SLEEP = 3;
    localparam int STB_N     = 4;

    // Control bits captured together with the data word
    typedef struct packed {
        logic range_x2;
        logic ref_buf;
    } dacif_ctrl_t;
endpackage

// File: rtl/dacif_strobe_filter.sv
// Strobe filter: two-flop synchronizer followed by a level acceptor.
// The accepted level changes only after two consecutive equal
// synchronized samples, so one-clock pulses are dropped. The rise and
// fall outputs are one-clock events aligned with the level change.
// Assumes an active-low strobe; the reset state is the idle level 1.
module dacif_strobe_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1, s2, s3;

    // Synchronize the raw strobe and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= strobe_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Accept a new level after two equal samples and flag the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b1;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (s2 == s3 && s2 != level) begin
                level <= s2;
                rise  <= s2;
                fall  <= ~s2;
            end
        end
    end

    // R10
    level_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s2) != $past(s3)) |-> $stable(level));

    // R11
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dacif_bundle_sync.sv
// Bundle synchronizer: two flops per bit for the select, half-select,
// control bits and data bus, so they line up with the filtered write.
// Assumes the host holds these signals stable around the write release.
module dacif_bundle_sync #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage sampling of the bundle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dacif_regs.sv
// Register core: staging register, converter code register, captured
// control bits, power-down flag and the code-change pulse.
// Assumes BUS_W < CODE_W <= 2*BUS_W and filtered, synchronous events.
module dacif_regs
    import dacif_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise,
    input  logic              load_fall,
    input  logic              load_lvl,
    input  logic              clr_lvl,
    input  logic              sleep_lvl,
    input  logic              sel_n_s,
    input  logic              upper_s,
    input  dacif_ctrl_t       ctrl_s,
    input  logic [BUS_W-1:0]  data_s,
    output logic [CODE_W-1:0] code_q,
    output dacif_ctrl_t       ctrl_q,
    output logic              pwr_q,
    output logic              upd_q
);
    localparam int HI_W = CODE_W - BUS_W;

    logic [CODE_W-1:0] stage_q, stage_nx, code_nx;
    dacif_ctrl_t       ctrl_nx;

    // Next-state: load, then write (which may also load), then clear
    always_comb begin
        stage_nx = stage_q;
        code_nx  = code_q;
        ctrl_nx  = ctrl_q;
        if (load_fall)
            code_nx = stage_q;
        if (wr_rise && !sel_n_s) begin
            if (upper_s)
                stage_nx[CODE_W-1:BUS_W] = data_s[HI_W-1:0];
            else
                stage_nx[BUS_W-1:0] = data_s;
            ctrl_nx = ctrl_s;
            if (!load_lvl)
                code_nx = stage_nx;
        end
        if (!clr_lvl) begin
            stage_nx = '0;
            code_nx  = '0;
            ctrl_nx  = '0;
        end
    end

    // State registers with the code-change flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            code_q  <= '0;
            ctrl_q  <= '0;
            pwr_q   <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            stage_q <= stage_nx;
            code_q  <= code_nx;
            ctrl_q  <= ctrl_nx;
            pwr_q   <= ~sleep_lvl;
            upd_q   <= (code_nx != code_q);
        end
    end

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl |=> (code_q == '0 && stage_q == '0));

    // R11
    upd_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> (code_q != $past(code_q)));

    // R11
    change_marks_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> upd_q);

    // R6
    async_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && !wr_rise && clr_lvl) |=> (code_q == $past(stage_q)));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rise && !load_fall && clr_lvl) |=> $stable(code_q));

    // R2
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && sel_n_s && clr_lvl) |=> $stable(stage_q));

    // R8
    por_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (code_q == '0 && !pwr_q && !upd_q));
endmodule

// File: rtl/dac_parallel_front.sv
// Top: converter parallel load interface. Filters the four strobes,
// synchronizes the data bundle alongside them and drives the register
// core. Assumes select, half-select, control bits and data are held
// stable from the write fall until three clocks after its release.
module dac_parallel_front
    import dacif_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic              load_n,
    input  logic              zero_n,
    input  logic              sleep_n,
    input  logic              upper_half,
    input  logic              range_x2,
    input  logic              ref_buffered,
    input  logic [BUS_W-1:0]  data_in,
    output logic [CODE_W-1:0] code_out,
    output logic              range_x2_out,
    output logic              ref_buffered_out,
    output logic              power_down,
    output logic              code_changed
);
    localparam int BW = BUS_W + 4;
    localparam logic [BW-1:0] BUNDLE_RST = {1'b1, {(BW-1){1'b0}}};

    logic [STB_N-1:0] stb_raw, stb_lvl, stb_rise, stb_fall;
    logic [BW-1:0]    bundle_raw, bundle_s;
    dacif_ctrl_t      ctrl_s, ctrl_q;

    assign stb_raw[STB_WR]    = wstb_n;
    assign stb_raw[STB_LOAD]  = load_n;
    assign stb_raw[STB_CLR]   = zero_n;
    assign stb_raw[STB_SLEEP] = sleep_n;

    // One filter per strobe
    for (genvar g = 0; g < STB_N; g++) begin : g_stb
        dacif_strobe_filter i_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (stb_raw[g]),
            .level    (stb_lvl[g]),
            .rise     (stb_rise[g]),
            .fall     (stb_fall[g])
        );
    end

    assign bundle_raw = {sel_n, upper_half, range_x2, ref_buffered, data_in};

    dacif_bundle_sync #(.W(BW), .RST_VAL(BUNDLE_RST)) i_bundle (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bundle_raw),
        .q     (bundle_s)
    );

    assign ctrl_s.range_x2 = bundle_s[BUS_W+1];
    assign ctrl_s.ref_buf  = bundle_s[BUS_W];

    dacif_regs #(.CODE_W(CODE_W), .BUS_W(BUS_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_rise   (stb_rise[STB_WR]),
        .load_fall (stb_fall[STB_LOAD]),
        .load_lvl  (stb_lvl[STB_LOAD]),
        .clr_lvl   (stb_lvl[STB_CLR]),
        .sleep_lvl (stb_lvl[STB_SLEEP]),
        .sel_n_s   (bundle_s[BUS_W+3]),
        .upper_s   (bundle_s[BUS_W+2]),
        .ctrl_s    (ctrl_s),
        .data_s    (bundle_s[BUS_W-1:0]),
        .code_q    (code_out),
        .ctrl_q    (ctrl_q),
        .pwr_q     (power_down),
        .upd_q     (code_changed)
    );

    assign range_x2_out     = ctrl_q.range_x2;
    assign ref_buffered_out = ctrl_q.ref_buf;
endmodule

// File: tb/test_dac_parallel_front.sv
`timescale 1ns/1ps
module test_dac_parallel_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, wstb_n = 1'b1, load_n = 1'b1, zero_n = 1'b1, sleep_n = 1'b1;
    logic upper_half = 1'b0, range_x2 = 1'b0, ref_buffered = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [11:0] code_out;
    logic range_x2_out, ref_buffered_out, power_down, code_changed;

    int compared = 0, mismatched = 0;
    int upd_seen = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    string phase = "R8 reset";

    always #2.5 clk = ~clk;

    dac_parallel_front i_dac_parallel_front (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .load_n(load_n),
        .zero_n(zero_n), .sleep_n(sleep_n), .upper_half(upper_half),
        .range_x2(range_x2), .ref_buffered(ref_buffered), .data_in(data_in),
        .code_out(code_out), .range_x2_out(range_x2_out),
        .ref_buffered_out(ref_buffered_out), .power_down(power_down),
        .code_changed(code_changed)
    );

    // Behavioural reference: accepted levels, registers, 3-edge output delay (R12)
    int m_stage = 0, m_code = 0, m_rng = 0, m_buf = 0, m_pd = 0, m_upd = 0;
    logic p_wr = 1, p_ld = 1, p_clr = 1, p_sl = 1;
    logic a_wr = 1, a_ld = 1, a_clr = 1, a_sl = 1;
    int h_code[4], h_rng[4], h_buf[4], h_pd[4], h_upd[4];

    initial for (int i = 0; i < 4; i++) begin
        h_code[i] = 0; h_rng[i] = 0; h_buf[i] = 0; h_pd[i] = 0; h_upd[i] = 0;
    end

    always @(posedge clk) begin
        bit wr_ev, ld_ev;
        int ns, nc, nr, nb;
        for (int i = 3; i > 0; i--) begin
            h_code[i] = h_code[i-1]; h_rng[i] = h_rng[i-1]; h_buf[i] = h_buf[i-1];
            h_pd[i] = h_pd[i-1]; h_upd[i] = h_upd[i-1];
        end
        if (!rst_n) begin
            m_stage = 0; m_code = 0; m_rng = 0; m_buf = 0; m_pd = 0; m_upd = 0;
            p_wr = 1; p_ld = 1; p_clr = 1; p_sl = 1;
            a_wr = 1; a_ld = 1; a_clr = 1; a_sl = 1;
        end else begin
            wr_ev = (wstb_n == p_wr) && wstb_n && !a_wr;
            ld_ev = (load_n == p_ld) && !load_n && a_ld;
            if (wstb_n == p_wr) a_wr = wstb_n;
            if (load_n == p_ld) a_ld = load_n;
            if (zero_n == p_clr) a_clr = zero_n;
            if (sleep_n == p_sl) a_sl = sleep_n;
            ns = m_stage; nc = m_code; nr = m_rng; nb = m_buf;
            if (ld_ev) nc = m_stage;
            if (wr_ev && !sel_n) begin
                if (upper_half) ns = (m_stage & 'h0FF) | ((int'(data_in) & 'hF) << 8);
                else            ns = (m_stage & 'hF00) | int'(data_in);
                nr = range_x2; nb = ref_buffered;
                if (!a_ld) nc = ns;
            end
            if (!a_clr) begin ns = 0; nc = 0; nr = 0; nb = 0; end
            m_upd = (nc != m_code);
            m_stage = ns; m_code = nc; m_rng = nr; m_buf = nb;
            m_pd = !a_sl;
            p_wr = wstb_n; p_ld = load_n; p_clr = zero_n; p_sl = sleep_n;
        end
        h_code[0] = m_code; h_rng[0] = m_rng; h_buf[0] = m_buf;
        h_pd[0] = m_pd; h_upd[0] = m_upd;
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (code_changed === 1'b1) upd_seen++;
        if (cmp_en) begin
            compared++;
            if (int'(code_out) !== h_code[3] || int'(range_x2_out) !== h_rng[3] ||
                int'(ref_buffered_out) !== h_buf[3] || int'(power_down) !== h_pd[3] ||
                int'(code_changed) !== h_upd[3]) begin
                mismatched++;
                $display("FAIL %s: code=%h rng=%0d buf=%0d pd=%0d upd=%0d expected code=%h rng=%0d buf=%0d pd=%0d upd=%0d",
                         phase, code_out, range_x2_out, ref_buffered_out, power_down, code_changed,
                         h_code[3], h_rng[3], h_buf[3], h_pd[3], h_upd[3]);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input bit sel, input bit hi, input logic [7:0] d,
                            input bit rg, input bit bf, input bit sync, input int low_len);
        @(negedge clk);
        sel_n = sel; upper_half = hi; data_in = d; range_x2 = rg; ref_buffered = bf;
        if (sync) begin load_n = 1'b0; idle(3); end
        wstb_n = 1'b0;
        idle(low_len);
        wstb_n = 1'b1;
        idle(4);
        sel_n = 1'b1;
        if (sync) load_n = 1'b1;
        idle(6);
    endtask

    task automatic load_pulse(input int len);
        @(negedge clk);
        load_n = 1'b0;
        idle(len);
        load_n = 1'b1;
        idle(7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        cmp_en = 1'b1;
        // R8 reset state
        check("R8 code", int'(code_out), 0);
        check("R8 ctrl", int'({range_x2_out, ref_buffered_out, power_down, code_changed}), 0);

        // R1 R4 R6: low write without load leaves the code alone
        phase = "R1 R4 R6 low write";
        do_write(1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b0, 3);
        check("R6 no load keeps code", int'(code_out), 0);
        check("R4 range captured", int'(range_x2_out), 1);

        // R3 upper write, then R6 load
        phase = "R3 upper write";
        do_write(1'b0, 1'b1, 8'hF3, 1'b0, 1'b1, 1'b0, 3);
        check("R4 buf captured", int'(ref_buffered_out), 1);
        phase = "R6 async load";
        load_pulse(3);
        check("R3 R6 code", int'(code_out), 'h3A5);

        // R2 deselected write
        phase = "R2 deselected";
        do_write(1'b1, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 3);
        load_pulse(3);
        check("R2 code", int'(code_out), 'h3A5);
        check("R2 buf", int'(ref_buffered_out), 1);

        // R5 synchronous update
        phase = "R5 sync write";
        do_write(1'b0, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1, 3);
        check("R5 code", int'(code_out), 'h30F);

        // R10 one-clock pulses ignored, two-clock accepted
        phase = "R10 short pulses";
        do_write(1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 1);
        load_pulse(1);
        check("R10 short pulses", int'(code_out), 'h30F);
        upd_seen = 0;
        load_pulse(2);
        check("R10 stage unchanged", int'(code_out), 'h30F);
        check("R11 same value no pulse", upd_seen, 0);

        // R9 power-down
        phase = "R9 sleep";
        @(negedge clk); sleep_n = 1'b0; idle(6);
        check("R9 power_down", int'(power_down), 1);
        check("R9 code kept", int'(code_out), 'h30F);
        sleep_n = 1'b1; idle(6);
        check("R9 power_down off", int'(power_down), 0);

        // R7 clear during a write
        phase = "R7 clear";
        @(negedge clk); sel_n = 1'b0; data_in = 8'h55; range_x2 = 1'b1; wstb_n = 1'b0;
        idle(2); zero_n = 1'b0; idle(2); wstb_n = 1'b1; idle(4); sel_n = 1'b1;
        load_n = 1'b0; idle(3); load_n = 1'b1; idle(2);
        zero_n = 1'b1; idle(8);
        check("R7 code zero", int'(code_out), 0);
        check("R7 range zero", int'(range_x2_out), 0);
        load_pulse(2);
        check("R7 stage zero", int'(code_out), 0);

        // R11 pulse counting
        phase = "R11 pulses";
        upd_seen = 0;
        do_write(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2);
        load_pulse(2);
        check("R11 reload zero", upd_seen, 0);
        do_write(1'b0, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 2);
        upd_seen = 0;
        load_pulse(2);
        check("R11 one pulse", upd_seen, 1);
        check("R11 code", int'(code_out), 'h012);

        // R12 latency: new code after the fifth edge from the load fall
        phase = "R12 latency";
        do_write(1'b0, 1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 2);
        @(negedge clk); load_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R12 before", int'(code_out), 'h012);
        load_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R12 after", int'(code_out), 'hC12);
        idle(8);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule